// File: doc/BRIEF.md
# Selectable-Source Bit-Rate Tick Generator

This block makes the 1x bit-rate enable that a serial transmitter or receiver shifter advances on. It divides one of two time bases down to the programmed rate. The first time base is the system clock itself, which passes through a fixed divide-by-4 prescaler. The second is a crystal-derived enable pulse that arrives already synchronised to the system clock. That pulse passes through a prescaler that divides by 3, or by 2 when the halving bit is set. A 23-bit reload counter sits behind the selected prescaler and divides the prescaled rate by N+1.

The block takes a 32-bit configuration word. It compares the word with the copy it holds on every cycle. Whenever any bit differs, it restarts both prescalers and the reload counter from the new value, so software never sees a partial period after it reprograms the rate. Software chooses N as the rounded value of source rate / prescale / baud, minus one, for rates between 50 and 4,000,000 baud.

Top module: `baud_div_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `tick_o` is low.
- R2: While configuration bit 23 (divisor enable) is 0, `tick_o` stays low, whatever the other bits and `xtal_en` do.
- R3: With bit 23 set and bit 24 (source select) at 0, `tick_o` pulses once every 4*(N+1) system clock cycles, where N is bits 22:0.
- R4: With bits 23 and 24 set and bit 27 (crystal halve) at 0, `tick_o` pulses once every 3*(N+1) `xtal_en` pulses.
- R5: With bits 23, 24 and 27 set, `tick_o` pulses once every 2*(N+1) `xtal_en` pulses.
- R6: When bit 24 is 0, bit 27 has no effect: the prescale stays 4.
- R7: The cycle in which `cfg_word` differs from the previously sampled word reloads the block, even when only an unused bit changes. No tick is emitted at that edge, and a source enable sampled at that edge is not counted. The first tick comes at the edge that samples the P*(N+1)-th source enable after the reload edge.
- R8: Each tick lasts exactly one system clock cycle.
- R9: When bit 24 is 0, `xtal_en` has no effect on the tick timing.
- R10: N = 0 is legal and gives one tick every P source enables, where P is the selected prescale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the source for the peripheral path |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Configuration: [22:0] N, [23] divisor enable, [24] crystal select, [27] crystal halve |
| xtal_en | input | 1 | One-cycle enable per crystal period, synchronous to `clk` |
| tick_o | output | 1 | Registered one-cycle bit-rate tick |

## Verification
Two things can fall on the same edge: a reload caused by a configuration change, and the terminal count of the divisor, with a crystal enable present as well. The bench waits for a tick and then changes the word exactly one period later, so that the change lands on the edge where the next tick is due. It does this on both the peripheral path and the crystal path, and on the crystal path it holds `xtal_en` high at that edge. A behavioural model counts the remaining source enables and compares `tick_o` on every cycle. The model expects the reload to win: no tick at that edge, the coincident enable discarded, and a full fresh period counted from there.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;
  localparam int unsigned CFG_W     = 32;
  localparam int unsigned DIV_W     = 23;
  localparam int unsigned BIT_USE   = 23;
  localparam int unsigned BIT_XSEL  = 24;
  localparam int unsigned BIT_XHALF = 27;

  typedef struct packed {
    logic             use_div;
    logic             xtal_sel;
    logic             xtal_half;
    logic [DIV_W-1:0] divisor;
  } baud_cfg_t;

  function automatic baud_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    baud_cfg_t c;
    c.use_div   = w[BIT_USE];
    c.xtal_sel  = w[BIT_XSEL];
    c.xtal_half = w[BIT_XHALF];
    c.divisor   = w[DIV_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/baud_cfg_track.sv
module baud_cfg_track #(
  parameter int unsigned CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_in,
  output logic [CFG_W-1:0] cfg_q,
  output logic             reload
);
  // Any bit change against the held copy restarts the divider chain.
  assign reload = !rst && (cfg_in != cfg_q);

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_in;
  end

  AST_HELD_COPY: assert property (@(posedge clk) disable iff (rst)
    reload |=> (cfg_q == $past(cfg_in))); // R7
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             src_en,
  input  logic [CNT_W-1:0] last,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (src_en)  cnt <= (cnt == last) ? '0 : cnt + 1'b1;
  end

  assign pulse = src_en && !clr && (cnt == last);

  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= last); // R4
  AST_PRESCALE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0)); // R7
endmodule

// File: rtl/baud_tick_count.sv
module baud_tick_count #(
  parameter int unsigned DIV_W = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             hold,
  input  logic             step,
  input  logic [DIV_W-1:0] n_new,
  input  logic [DIV_W-1:0] n_cur,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (load) begin
      cnt  <= n_new;
      tick <= 1'b0;
    end else if (hold) begin
      tick <= 1'b0;
    end else begin
      tick <= step && (cnt == '0);
      if (step) cnt <= (cnt == '0) ? n_cur : cnt - 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= n_cur); // R3
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R8
endmodule

// File: rtl/baud_div_gen.sv
module baud_div_gen
  import baud_div_pkg::*;
#(
  parameter int unsigned PERIPH_DIV = 4,
  parameter int unsigned XTAL_SLOW  = 3,
  parameter int unsigned XTAL_FAST  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             xtal_en,
  output logic             tick_o
);
  localparam int unsigned NPATH = 2;
  localparam int unsigned MAXP  = (PERIPH_DIV > XTAL_SLOW) ?
                                  ((PERIPH_DIV > XTAL_FAST) ? PERIPH_DIV : XTAL_FAST) :
                                  ((XTAL_SLOW > XTAL_FAST) ? XTAL_SLOW : XTAL_FAST);
  localparam int unsigned PRE_W = (MAXP > 2) ? $clog2(MAXP) : 1;

  logic [CFG_W-1:0] cfg_q;
  logic             reload;
  baud_cfg_t        cur, nxt;
  logic [NPATH-1:0] pre_pulse;
  logic             step;

  baud_cfg_track #(.CFG_W(CFG_W)) u_track (
    .clk(clk), .rst(rst), .cfg_in(cfg_word), .cfg_q(cfg_q), .reload(reload)
  );

  assign cur = decode_cfg(cfg_q);
  assign nxt = decode_cfg(cfg_word);

  // Path 0: system clock / PERIPH_DIV. Path 1: crystal enables / 3 or 2.
  for (genvar p = 0; p < NPATH; p++) begin : g_path
    logic             src;
    logic [PRE_W-1:0] last;
    if (p == 0) begin : g_periph
      assign src  = 1'b1;
      assign last = PRE_W'(PERIPH_DIV - 1);
    end else begin : g_xtal
      assign src  = xtal_en;
      assign last = cur.xtal_half ? PRE_W'(XTAL_FAST - 1) : PRE_W'(XTAL_SLOW - 1);
    end
    baud_prescale #(.CNT_W(PRE_W)) u_pre (
      .clk(clk), .rst(rst), .clr(reload || !cur.use_div),
      .src_en(src), .last(last), .pulse(pre_pulse[p])
    );
  end

  assign step = cur.xtal_sel ? pre_pulse[1] : pre_pulse[0];

  baud_tick_count #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst(rst), .load(reload), .hold(!cur.use_div), .step(step),
    .n_new(nxt.divisor), .n_cur(cur.divisor), .tick(tick_o)
  );

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !cfg_word[BIT_USE] |=> !tick_o); // R2
  AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    reload |=> !tick_o); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !tick_o); // R1
endmodule

// File: tb/test_baud_div_gen.sv
module test_baud_div_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_word = '0;
  logic        xtal_en = 1'b0;
  logic        tick_o;

  baud_div_gen i_baud_div_gen (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .xtal_en(xtal_en), .tick_o(tick_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  string req = "R1";
  int    xmode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int    cyc = 0;
  bit    done = 0;

  // Crystal enable pattern: 0 none, 1 every cycle, 2 pseudo-random.
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (xmode)
      1:       xtal_en <= 1'b1;
      2:       xtal_en <= lfsr[3];
      default: xtal_en <= 1'b0;
    endcase
  end

  // Behavioural reference: remaining source enables until the next tick.
  logic [31:0] m_prev = '0;
  longint      m_rem = 0;
  bit          exp_tick = 0;

  function automatic longint period_of(input logic [31:0] w);
    longint pre;
    pre = w[24] ? (w[27] ? 2 : 3) : 4;
    return pre * (longint'(w[22:0]) + 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_prev = '0; m_rem = 0; exp_tick = 0;
    end else if (cfg_word != m_prev) begin
      m_prev = cfg_word; m_rem = period_of(cfg_word); exp_tick = 0;
    end else if (!m_prev[23]) begin
      exp_tick = 0;
    end else begin
      exp_tick = 0;
      if (m_prev[24] ? xtal_en : 1'b1) begin
        m_rem--;
        if (m_rem == 0) begin
          exp_tick = 1;
          m_rem = period_of(m_prev);
        end
      end
    end
  end

  bit last_tick = 0;
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (tick_o !== exp_tick) begin
        errors++;
        $display("FAIL %s cycle %0d: tick_o=%b expected %b", req, cyc, tick_o, exp_tick);
      end
      if (tick_o) begin
        checks++; // R8 width check
        if (last_tick) begin
          errors++;
          $display("FAIL R8 cycle %0d: tick high two cycles, got 1 expected 0", cyc);
        end
      end
      last_tick = tick_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: cycles %0d expected below %0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_tick();
    int guard = 0;
    @(negedge clk);
    while (tick_o !== 1'b1 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    run(4);                               // R1: low during reset
    rst = 1'b0;
    run(2);                               // R1: low after release
    req = "R2"; xmode = 1;
    cfg_word = 32'h0100_0002; run(30);    // crystal selected, bit 23 clear
    cfg_word = 32'h0800_0005; run(30);    // peripheral, bit 23 clear
    req = "R3"; xmode = 0;
    cfg_word = (32'd1 << 23) | 32'd2; run(60);
    req = "R10";
    cfg_word = (32'd1 << 23); run(24);
    req = "R3";
    cfg_word = (32'd1 << 23) | 32'd100; run(900);
    req = "R6";
    cfg_word = (32'd1 << 23) | (32'd1 << 27) | 32'd1; run(40);
    req = "R9"; xmode = 2; run(60);
    req = "R4";
    cfg_word = (32'd1 << 23) | (32'd1 << 24) | 32'd1; run(120);
    req = "R10"; xmode = 1;
    cfg_word = (32'd1 << 23) | (32'd1 << 24); run(30);
    req = "R5";
    cfg_word = (32'd1 << 23) | (32'd1 << 24) | (32'd1 << 27) | 32'd3; run(60);
    xmode = 2; run(80);
    req = "R7"; xmode = 0;
    cfg_word = (32'd1 << 23) | 32'd4; run(7);
    cfg_word = cfg_word | (32'd1 << 30); run(40);   // unused bit still reloads
    wait_tick(); run(19);                            // change on tick-due edge
    cfg_word = (32'd1 << 23) | 32'd2; run(40);
    xmode = 1;
    cfg_word = (32'd1 << 23) | (32'd1 << 24) | (32'd1 << 27); run(6);
    wait_tick(); run(1);                             // crystal path collision
    cfg_word = (32'd1 << 23) | (32'd1 << 24) | (32'd1 << 27) | 32'd1; run(30);
    req = "R8";
    cfg_word = (32'd1 << 23) | (32'd1 << 24) | (32'd1 << 27); run(40);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule